// File: doc/BRIEF.md
# GMII to RGMII Bridge

This block converts between a byte-wide, single-data-rate gigabit media-independent interface and the reduced, double-data-rate form used at the pins of an external gigabit transceiver. It runs in gigabit full-duplex operation only. On the transmit side, each 125 MHz cycle carries one byte with its enable and error strobes, and the block splits that byte into two 4-bit nibbles on a single control line. Both clock edges carry data, so the transceiver interface needs half as many data pins.

The transmit clock sent to the transceiver is built from a second 125 MHz clock that lags the core clock by a quarter period. Its edges therefore fall in the middle of each data nibble. On the receive side, the block samples the nibbles and the control line on both edges of the clock recovered by the transceiver. It then puts the byte, a valid flag and an error flag back together in that clock's domain. The double-rate registers are modelled behaviourally: one register is clocked on each edge, and the pair is combined with an exclusive-or.

Top module: `gmii_rgmii_bridge`

## Requirements
- R1: While rst_ni is low, every output (rgmii_txd_o, rgmii_tx_ctl_o, rgmii_txc_o, gmii_rxd_o, gmii_rx_dv_o, gmii_rx_er_o) is 0.
- R2: The rising edge of clk_i samples the transmit byte. While clk_i is high after that edge, rgmii_txd_o carries bits [3:0] of the sampled byte.
- R3: While clk_i is low, in the same cycle, rgmii_txd_o carries bits [7:4] of the byte sampled at the preceding rising edge.
- R4: While clk_i is high, rgmii_tx_ctl_o equals the sampled transmit enable.
- R5: While clk_i is low, rgmii_tx_ctl_o equals the sampled enable XOR the sampled error.
- R6: When the sampled transmit enable is 0, rgmii_txd_o and rgmii_tx_ctl_o are 0 in both halves of the cycle, whatever the values of the transmit data and the error input.
- R7: rgmii_txc_o follows clk90_i. It is 1 at the falling edge of clk_i and 0 at its rising edge, so its edges sit mid-way through each data nibble.
- R8: The nibble sampled at a rising edge of rgmii_rxc_i becomes gmii_rxd_o[3:0]. The nibble sampled at the following falling edge becomes gmii_rxd_o[7:4]. Both appear together after the next rising edge.
- R9: gmii_rx_dv_o equals the control bit sampled at the rising edge. It is updated on the same edge as the data.
- R10: gmii_rx_er_o equals the XOR of the control bits sampled at the rising edge and at the falling edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | 125 MHz core transmit clock |
| clk90_i | input | 1 | Copy of clk_i lagging by 90 degrees |
| rst_ni | input | 1 | Active-low asynchronous reset |
| gmii_txd_i | input | 8 | Transmit byte |
| gmii_tx_en_i | input | 1 | Transmit enable |
| gmii_tx_er_i | input | 1 | Transmit error |
| rgmii_txc_o | output | 1 | Forwarded transmit clock |
| rgmii_txd_o | output | 4 | Transmit nibble, both edges |
| rgmii_tx_ctl_o | output | 1 | Transmit control, both edges |
| rgmii_rxc_i | input | 1 | Receive clock from transceiver |
| rgmii_rxd_i | input | 4 | Receive nibble, both edges |
| rgmii_rx_ctl_i | input | 1 | Receive control, both edges |
| gmii_rxd_o | output | 8 | Reassembled receive byte |
| gmii_rx_dv_o | output | 1 | Receive data valid |
| gmii_rx_er_o | output | 1 | Receive error |

## Verification
On transmit, the low nibble and the enable are due in the high half of the same clk_i cycle that samples the byte. The high nibble and the combined control bit are due in the low half of that cycle. The bench changes its inputs at a falling edge and reads the outputs 3 ns and 13 ns after the next rising edge, so each read falls inside the half it targets and away from every edge. It reads the forwarded clock 7 ns and 17 ns after that rising edge, between the edges of clk90_i. On receive, a byte is due one full rxc cycle after its low nibble is sampled, so the bench reads it 2 ns after the second rising edge.

// File: rtl/gmii_rgmii_pkg.sv
package gmii_rgmii_pkg;
  localparam int unsigned NIB_W  = 4;
  localparam int unsigned BYTE_W = 2 * NIB_W;
endpackage

// File: rtl/ddr_out.sv
// Behavioural double-rate output: rise word shown in high phase, fall word in low phase.
module ddr_out #(
  parameter int unsigned W = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_rise_i,
  input  logic [W-1:0] d_fall_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] p_q, n_q, fall_hold_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      p_q         <= '0;
      fall_hold_q <= '0;
    end else begin
      p_q         <= d_rise_i ^ n_q;
      fall_hold_q <= d_fall_i;
    end
  end

  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) n_q <= '0;
    else         n_q <= fall_hold_q ^ p_q;
  end

  assign q_o = p_q ^ n_q;
endmodule

// File: rtl/ddr_in.sv
// Behavioural double-rate capture: one register per edge.
module ddr_in #(
  parameter int unsigned W = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_rise_o,
  output logic [W-1:0] q_fall_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_rise_o <= '0;
    else         q_rise_o <= d_i;
  end

  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_fall_o <= '0;
    else         q_fall_o <= d_i;
  end
endmodule

// File: rtl/rgmii_tx_enc.sv
module rgmii_tx_enc #(
  parameter int unsigned NIB_W = gmii_rgmii_pkg::NIB_W
) (
  input  logic [2*NIB_W-1:0] txd_i,
  input  logic               tx_en_i,
  input  logic               tx_er_i,
  output logic [NIB_W:0]     rise_o,
  output logic [NIB_W:0]     fall_o
);
  logic [NIB_W-1:0] lo, hi;

  // idle: data and control held low on both edges
  always_comb begin
    lo     = tx_en_i ? txd_i[NIB_W-1:0]       : '0;
    hi     = tx_en_i ? txd_i[2*NIB_W-1:NIB_W] : '0;
    rise_o = {tx_en_i, lo};
    fall_o = {tx_en_i & (tx_en_i ^ tx_er_i), hi};
  end
endmodule

// File: rtl/rgmii_rx_dec.sv
module rgmii_rx_dec #(
  parameter int unsigned NIB_W = gmii_rgmii_pkg::NIB_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NIB_W:0]     rise_i,
  input  logic [NIB_W:0]     fall_i,
  output logic [2*NIB_W-1:0] rxd_o,
  output logic               rx_dv_o,
  output logic               rx_er_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rxd_o   <= '0;
      rx_dv_o <= 1'b0;
      rx_er_o <= 1'b0;
    end else begin
      rxd_o   <= {fall_i[NIB_W-1:0], rise_i[NIB_W-1:0]};
      rx_dv_o <= rise_i[NIB_W];
      rx_er_o <= rise_i[NIB_W] ^ fall_i[NIB_W];
    end
  end
endmodule

// File: rtl/gmii_rgmii_bridge.sv
module gmii_rgmii_bridge #(
  parameter int unsigned NIB_W  = gmii_rgmii_pkg::NIB_W,
  localparam int unsigned BYTE_W = 2 * NIB_W
) (
  input  logic              clk_i,
  input  logic              clk90_i,
  input  logic              rst_ni,
  input  logic [BYTE_W-1:0] gmii_txd_i,
  input  logic              gmii_tx_en_i,
  input  logic              gmii_tx_er_i,
  output logic              rgmii_txc_o,
  output logic [NIB_W-1:0]  rgmii_txd_o,
  output logic              rgmii_tx_ctl_o,
  input  logic              rgmii_rxc_i,
  input  logic [NIB_W-1:0]  rgmii_rxd_i,
  input  logic              rgmii_rx_ctl_i,
  output logic [BYTE_W-1:0] gmii_rxd_o,
  output logic              gmii_rx_dv_o,
  output logic              gmii_rx_er_o
);
  logic [NIB_W:0] tx_rise, tx_fall, tx_pins;
  logic [NIB_W:0] rx_rise, rx_fall;

  rgmii_tx_enc #(.NIB_W(NIB_W)) u_tx_enc (
    .txd_i   (gmii_txd_i),
    .tx_en_i (gmii_tx_en_i),
    .tx_er_i (gmii_tx_er_i),
    .rise_o  (tx_rise),
    .fall_o  (tx_fall)
  );

  ddr_out #(.W(NIB_W + 1)) u_tx_ddr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .d_rise_i (tx_rise),
    .d_fall_i (tx_fall),
    .q_o      (tx_pins)
  );

  assign rgmii_txd_o    = tx_pins[NIB_W-1:0];
  assign rgmii_tx_ctl_o = tx_pins[NIB_W];

  // forwarded clock: constant 1/0 pattern through a double-rate cell on the shifted clock
  ddr_out #(.W(1)) u_txc_ddr (
    .clk_i    (clk90_i),
    .rst_ni   (rst_ni),
    .d_rise_i (1'b1),
    .d_fall_i (1'b0),
    .q_o      (rgmii_txc_o)
  );

  ddr_in #(.W(NIB_W + 1)) u_rx_ddr (
    .clk_i    (rgmii_rxc_i),
    .rst_ni   (rst_ni),
    .d_i      ({rgmii_rx_ctl_i, rgmii_rxd_i}),
    .q_rise_o (rx_rise),
    .q_fall_o (rx_fall)
  );

  rgmii_rx_dec #(.NIB_W(NIB_W)) u_rx_dec (
    .clk_i   (rgmii_rxc_i),
    .rst_ni  (rst_ni),
    .rise_i  (rx_rise),
    .fall_i  (rx_fall),
    .rxd_o   (gmii_rxd_o),
    .rx_dv_o (gmii_rx_dv_o),
    .rx_er_o (gmii_rx_er_o)
  );
endmodule

// File: rtl/gmii_rgmii_bridge_chk.sv
module gmii_rgmii_bridge_chk #(
  parameter int unsigned NIB_W  = gmii_rgmii_pkg::NIB_W,
  localparam int unsigned BYTE_W = 2 * NIB_W
) (
  input logic              clk_i,
  input logic              clk90_i,
  input logic              rst_ni,
  input logic [BYTE_W-1:0] gmii_txd_i,
  input logic              gmii_tx_en_i,
  input logic              gmii_tx_er_i,
  input logic              rgmii_txc_o,
  input logic [NIB_W-1:0]  rgmii_txd_o,
  input logic              rgmii_tx_ctl_o,
  input logic              rgmii_rxc_i,
  input logic [NIB_W-1:0]  rgmii_rxd_i,
  input logic              rgmii_rx_ctl_i,
  input logic [BYTE_W-1:0] gmii_rxd_o,
  input logic              gmii_rx_dv_o,
  input logic              gmii_rx_er_o
);
  logic [BYTE_W-1:0] cap_d;
  logic              cap_en, cap_er, cap_v;
  logic [1:0]        run_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cap_d <= '0; cap_en <= 1'b0; cap_er <= 1'b0; cap_v <= 1'b0; run_cnt <= '0;
    end else begin
      cap_d <= gmii_txd_i; cap_en <= gmii_tx_en_i; cap_er <= gmii_tx_er_i; cap_v <= 1'b1;
      if (run_cnt != 2'd2) run_cnt <= run_cnt + 2'd1;
    end
  end

  logic [NIB_W-1:0]  r_d, f_d;
  logic              r_c, f_c, r_seen, f_seen, exp_v;
  logic [BYTE_W-1:0] exp_d;
  logic              exp_dv, exp_er;

  always_ff @(posedge rgmii_rxc_i or negedge rst_ni) begin
    if (!rst_ni) begin
      r_d <= '0; r_c <= 1'b0; r_seen <= 1'b0;
      exp_d <= '0; exp_dv <= 1'b0; exp_er <= 1'b0; exp_v <= 1'b0;
    end else begin
      r_d <= rgmii_rxd_i; r_c <= rgmii_rx_ctl_i; r_seen <= 1'b1;
      exp_d <= {f_d, r_d}; exp_dv <= r_c; exp_er <= r_c ^ f_c; exp_v <= f_seen;
    end
  end

  always_ff @(negedge rgmii_rxc_i or negedge rst_ni) begin
    if (!rst_ni) begin
      f_d <= '0; f_c <= 1'b0; f_seen <= 1'b0;
    end else begin
      f_d <= rgmii_rxd_i; f_c <= rgmii_rx_ctl_i; f_seen <= r_seen;
    end
  end

  assert_tx_lo_R2: assert property (@(negedge clk_i) disable iff (!rst_ni)
    cap_v && cap_en |-> rgmii_txd_o == cap_d[NIB_W-1:0]);
  assert_tx_hi_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_v && cap_en |-> rgmii_txd_o == cap_d[BYTE_W-1:NIB_W]);
  assert_ctl_rise_R4: assert property (@(negedge clk_i) disable iff (!rst_ni)
    cap_v |-> rgmii_tx_ctl_o == cap_en);
  assert_ctl_fall_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_v && cap_en |-> rgmii_tx_ctl_o == (cap_en ^ cap_er));
  assert_idle_low_R6: assert property (@(negedge clk_i) disable iff (!rst_ni)
    cap_v && !cap_en |-> rgmii_txd_o == '0);
  assert_idle_low_fall_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_v && !cap_en |-> rgmii_txd_o == '0 && !rgmii_tx_ctl_o);
  assert_txc_high_R7: assert property (@(negedge clk_i) disable iff (!rst_ni)
    run_cnt == 2'd2 |-> rgmii_txc_o);
  assert_txc_low_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_cnt == 2'd2 |-> !rgmii_txc_o);
  assert_rx_data_R8: assert property (@(negedge rgmii_rxc_i) disable iff (!rst_ni)
    exp_v |-> gmii_rxd_o == exp_d);
  assert_rx_dv_R9: assert property (@(negedge rgmii_rxc_i) disable iff (!rst_ni)
    exp_v |-> gmii_rx_dv_o == exp_dv);
  assert_rx_er_R10: assert property (@(negedge rgmii_rxc_i) disable iff (!rst_ni)
    exp_v |-> gmii_rx_er_o == exp_er);
endmodule

bind gmii_rgmii_bridge gmii_rgmii_bridge_chk #(.NIB_W(NIB_W)) u_chk (.*);

// File: tb/gmii_rgmii_bridge_tb.sv
`timescale 1ns/1ps
module gmii_rgmii_bridge_tb;
  logic       clk_i = 1'b0, clk90_i = 1'b0, rxc = 1'b0, rst_ni = 1'b0;
  logic [7:0] txd = '0;
  logic       tx_en = 1'b0, tx_er = 1'b0;
  logic [3:0] rxd = '0;
  logic       rx_ctl = 1'b0;
  logic       txc_o, tx_ctl_o, rx_dv_o, rx_er_o;
  logic [3:0] txd_o;
  logic [7:0] rxd_o;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #10 clk_i = ~clk_i;
  initial begin #5; forever #10 clk90_i = ~clk90_i; end
  initial begin #3; forever #10 rxc = ~rxc; end

  gmii_rgmii_bridge u_dut (
    .clk_i(clk_i), .clk90_i(clk90_i), .rst_ni(rst_ni),
    .gmii_txd_i(txd), .gmii_tx_en_i(tx_en), .gmii_tx_er_i(tx_er),
    .rgmii_txc_o(txc_o), .rgmii_txd_o(txd_o), .rgmii_tx_ctl_o(tx_ctl_o),
    .rgmii_rxc_i(rxc), .rgmii_rxd_i(rxd), .rgmii_rx_ctl_i(rx_ctl),
    .gmii_rxd_o(rxd_o), .gmii_rx_dv_o(rx_dv_o), .gmii_rx_er_o(rx_er_o)
  );

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] exp_nib(logic [7:0] d, logic en, bit hi);
    return en ? (hi ? d[7:4] : d[3:0]) : 4'h0;
  endfunction
  function automatic logic exp_ctl(logic en, logic er, bit hi);
    return hi ? (en & (en ^ er)) : en;
  endfunction

  task automatic tx_word(logic [7:0] d, logic en, logic er);
    @(negedge clk_i);
    txd = d; tx_en = en; tx_er = er;
    @(posedge clk_i);
    #3;  check(en ? "R2" : "R6", {4'h0, txd_o}, {4'h0, exp_nib(d, en, 1'b0)});
         check(en ? "R4" : "R6", {7'h0, tx_ctl_o}, {7'h0, exp_ctl(en, er, 1'b0)});
    #4;  check("R7", {7'h0, txc_o}, 8'h01);
    #6;  check(en ? "R3" : "R6", {4'h0, txd_o}, {4'h0, exp_nib(d, en, 1'b1)});
         check(en ? "R5" : "R6", {7'h0, tx_ctl_o}, {7'h0, exp_ctl(en, er, 1'b1)});
    #4;  check("R7", {7'h0, txc_o}, 8'h00);
  endtask

  task automatic rx_word(logic [7:0] d, logic dv, logic er);
    rxd = d[3:0]; rx_ctl = dv;
    @(posedge rxc); #4;
    rxd = d[7:4]; rx_ctl = dv ^ er;
    @(posedge rxc); #2;
    check("R8", rxd_o, d);
    check("R9", {7'h0, rx_dv_o}, {7'h0, dv});
    check("R10", {7'h0, rx_er_o}, {7'h0, er});
  endtask

  initial begin
    void'($urandom(32'h5eed_0042));
    // R1: outputs low during reset while inputs toggle
    txd = 8'hA5; tx_en = 1'b1; tx_er = 1'b1; rxd = 4'hF; rx_ctl = 1'b1;
    repeat (3) @(posedge clk_i);
    #3;  check("R1", {txc_o, tx_ctl_o, 2'b0, txd_o}, 8'h00);
         check("R1", rxd_o, 8'h00);
         check("R1", {6'h0, rx_dv_o, rx_er_o}, 8'h00);
    #10; check("R1", {txc_o, tx_ctl_o, 2'b0, txd_o}, 8'h00);
    @(negedge clk_i); rst_ni = 1'b1;
    tx_en = 1'b0; tx_er = 1'b0;
    repeat (2) @(posedge clk_i);

    // directed corners
    tx_word(8'hFF, 1'b0, 1'b1);   // R6: idle with error and data set
    tx_word(8'h3C, 1'b0, 1'b0);   // R6
    tx_word(8'hA5, 1'b1, 1'b0);   // R2 R3 R4 R5
    tx_word(8'h5A, 1'b1, 1'b1);   // R5: error on enabled byte
    tx_word(8'h0F, 1'b1, 1'b0);
    tx_word(8'hF0, 1'b1, 1'b0);
    for (int i = 0; i < 60; i++)
      tx_word(8'($urandom), 1'($urandom), 1'($urandom));

    @(posedge rxc); #2;
    rx_word(8'h00, 1'b0, 1'b0);
    rx_word(8'hC3, 1'b1, 1'b0);   // R8 R9
    rx_word(8'h7E, 1'b1, 1'b1);   // R10: control 1 then 0
    rx_word(8'h81, 1'b0, 1'b1);   // R10: control 0 then 1
    rx_word(8'hF0, 1'b1, 1'b0);
    for (int i = 0; i < 60; i++)
      rx_word(8'($urandom), 1'($urandom), 1'($urandom));

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog act=running exp=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule